// File: doc/BRIEF.md
# Dual-Code Serial Line Encoder (FM0 / Manchester)

This block turns a serial stream of data bits into a line code for a short-range vehicle radio link. It can produce either FM0 (bi-phase space) or Manchester code. Both codes come out of one small datapath: two operand multiplexers feed a single XNOR, and a registered output stage follows it. Every element does work in both codes, so no logic sits idle in either mode.

The block runs on a clock at twice the bit rate, so each bit period has two half-slots. A half-select flip-flop tracks which slot is current. The block raises a strobe in the cycle before the edge that consumes a data bit. The upstream source presents the next bit while the strobe is high. The mode select is captured on that same edge, so a mode change never cuts a symbol short. A synchronous clear returns the encoder to a known idle state, and the next bit then starts in the first half-slot.

Top module: `line_encoder_top`

## Requirements
- R1: While `clr` is high, on every rising edge `line_out` goes to 0 and the half-select returns to the first slot. In the cycle after release, `bit_strobe` is 1. For FM0, the stored previous level counts as 0, so the first bit after a clear begins at level 1.
- R2: `bit_strobe` is 1 in every other cycle. `data_in` is sampled only on a rising edge where `bit_strobe` is 1. A change on `data_in` during a cycle where `bit_strobe` is 0 has no effect on the output.
- R3: With `mode` = 0 (FM0), the first-half level of each bit is the inverse of the second-half level of the previous bit.
- R4: In FM0, a data bit of 0 inverts the level at mid-bit, and a data bit of 1 holds the level through the whole bit. The second-half level is therefore the first-half level XNOR the data bit.
- R5: With `mode` = 1 (Manchester), the first half-slot carries the inverse of the data bit and the second half-slot carries the data bit. Every bit therefore has a mid-bit transition.
- R6: `mode` is sampled only on the same edge as `data_in`. A change on `mode` while `bit_strobe` is 0 does not alter the second half of the bit in progress.
- R7: The output is registered. The first-half level of a bit appears in the cycle after the sampling edge, and the second-half level appears one cycle later.
- R8: Over any run of whole Manchester bits, the number of half-slots at level 1 equals the number at level 0.
- R9: When the code switches from Manchester to FM0, the first FM0 half-slot is the inverse of the last Manchester half-slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| clr | input | 1 | Synchronous active-high clear |
| mode | input | 1 | Code select: 0 = FM0, 1 = Manchester |
| data_in | input | 1 | Data bit, consumed on the edge where `bit_strobe` is 1 |
| line_out | output | 1 | Registered serial line level |
| bit_strobe | output | 1 | High in the cycle before the edge that samples `data_in` and `mode` |

## Verification
A scoreboard predicts every half-slot level from a reference model. Any mistake in the boundary inversion, the mid-bit rule, or the slot order then shows up as a wrong level in a specific half-slot.

The bench flips `data_in` and `mode` in the middle of a bit. A design that samples either input on the wrong edge would then emit a corrupted second half.

It clears the block mid-stream. A design that kept its stored FM0 level, or its half-select, would start the next bit at the wrong level or in the wrong slot.

It also switches from Manchester back to FM0. A design that did not track the line level during Manchester would miss the boundary inversion at the first FM0 bit.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic {
    CODE_FM0 = 1'b0,
    CODE_MAN = 1'b1
  } code_e;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } slot_e;

endpackage

// File: rtl/lc_phase_ctrl.sv
module lc_phase_ctrl
  import lc_pkg::*;
(
  input  logic  clk,
  input  logic  clr,
  input  logic  data_in,
  input  code_e mode_in,
  output slot_e slot,
  output logic  data_hold,
  output code_e mode_hold,
  output logic  strobe
);

  slot_e slot_q;
  logic  data_q;
  code_e mode_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      slot_q <= SLOT_FIRST;
      data_q <= 1'b0;
      mode_q <= CODE_FM0;
    end else begin
      slot_q <= (slot_q == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
      if (slot_q == SLOT_FIRST) begin
        data_q <= data_in;
        mode_q <= mode_in;
      end
    end
  end

  assign slot      = slot_q;
  assign data_hold = data_q;
  assign mode_hold = mode_q;
  assign strobe    = (slot_q == SLOT_FIRST);

  // R2: the two half-slots alternate on every edge outside clear
  p_slot_alternates_r2: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> slot_q != $past(slot_q));

  // R6: the captured data bit and mode do not move during the second half
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (clr)
    (slot_q == SLOT_SECOND) |=> ($stable(mode_q) && $stable(data_q)));

endmodule

// File: rtl/lc_operand_sel.sv
module lc_operand_sel
  import lc_pkg::*;
(
  input  slot_e slot,
  input  code_e mode_now,
  input  code_e mode_hold,
  input  logic  data_now,
  input  logic  data_hold,
  input  logic  line_now,
  output logic  op_a,
  output logic  op_b
);

  // First slot:  FM0 -> XNOR(prev level, 0) ; Manchester -> XNOR(data, 0)
  // Second slot: FM0 -> XNOR(data, first-half level) ; Manchester -> XNOR(data, 1)
  always_comb begin
    if (slot == SLOT_SECOND) begin
      op_a = data_hold;
      op_b = (mode_hold == CODE_MAN) ? 1'b1 : line_now;
    end else begin
      op_a = (mode_now == CODE_MAN) ? data_now : line_now;
      op_b = 1'b0;
    end
  end

endmodule

// File: rtl/lc_xnor_stage.sv
module lc_xnor_stage #(
  parameter logic CLR_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic op_a,
  input  logic op_b,
  output logic line_q
);

  always_ff @(posedge clk) begin
    if (clr) line_q <= CLR_LEVEL;
    else     line_q <= ~(op_a ^ op_b);
  end

endmodule

// File: rtl/line_encoder_top.sv
module line_encoder_top
  import lc_pkg::*;
#(
  parameter logic CLR_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic mode,
  input  logic data_in,
  output logic line_out,
  output logic bit_strobe
);

  slot_e slot;
  logic  data_hold;
  code_e mode_hold;
  code_e mode_now;
  logic  op_a;
  logic  op_b;
  logic  line_q;

  assign mode_now = code_e'(mode);

  lc_phase_ctrl u_ctrl (
    .clk       (clk),
    .clr       (clr),
    .data_in   (data_in),
    .mode_in   (mode_now),
    .slot      (slot),
    .data_hold (data_hold),
    .mode_hold (mode_hold),
    .strobe    (bit_strobe)
  );

  lc_operand_sel u_sel (
    .slot      (slot),
    .mode_now  (mode_now),
    .mode_hold (mode_hold),
    .data_now  (data_in),
    .data_hold (data_hold),
    .line_now  (line_q),
    .op_a      (op_a),
    .op_b      (op_b)
  );

  lc_xnor_stage #(.CLR_LEVEL(CLR_LEVEL)) u_core (
    .clk    (clk),
    .clr    (clr),
    .op_a   (op_a),
    .op_b   (op_b),
    .line_q (line_q)
  );

  assign line_out = line_q;

  // R1: clear drives the idle level and the first slot
  p_clear_state_r1: assert property (@(posedge clk)
    clr |=> (line_q == CLR_LEVEL && bit_strobe));

  // R3: FM0 always inverts at a bit boundary
  p_fm0_boundary_r3: assert property (@(posedge clk) disable iff (clr)
    (bit_strobe && !mode) |=> line_q != $past(line_q));

  // R4: FM0 data 1 holds through mid-bit
  p_fm0_hold_one_r4: assert property (@(posedge clk) disable iff (clr)
    (!bit_strobe && mode_hold == CODE_FM0 && data_hold) |=> $stable(line_q));

  // R4: FM0 data 0 inverts at mid-bit
  p_fm0_flip_zero_r4: assert property (@(posedge clk) disable iff (clr)
    (!bit_strobe && mode_hold == CODE_FM0 && !data_hold) |=> !$stable(line_q));

  // R5: Manchester first half carries the inverted data bit
  p_man_first_r5: assert property (@(posedge clk) disable iff (clr)
    (bit_strobe && mode) |=> line_q == !$past(data_in));

  // R5: Manchester always transitions at mid-bit
  p_man_mid_r5: assert property (@(posedge clk) disable iff (clr)
    (!bit_strobe && mode_hold == CODE_MAN) |=> line_q != $past(line_q));

endmodule

// File: tb/tb_line_encoder_top.sv
module tb_line_encoder_top;

  typedef struct {
    logic  lvl;
    logic  man;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic mode = 1'b0;
  logic data_in = 1'b0;
  logic line_out;
  logic bit_strobe;

  int   checks = 0;
  int   errors = 0;
  int   man_hi = 0;
  int   man_lo = 0;
  logic model_prev = 1'b0;
  bit   finished = 1'b0;
  exp_t sb[$];
  exp_t mon_e;

  always #5 clk = ~clk;

  line_encoder_top dut (
    .clk        (clk),
    .clr        (clr),
    .mode       (mode),
    .data_in    (data_in),
    .line_out   (line_out),
    .bit_strobe (bit_strobe)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected half-slot level per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      mon_e = sb.pop_front();
      check(mon_e.tag, line_out, mon_e.lvl);
      if (mon_e.man) begin
        if (line_out) man_hi++;
        else          man_lo++;
      end
    end
  end

  // Driver: called at a falling edge; drives one bit, pushes its two half-slots
  task automatic send_bit(input logic x, input logic m, input logic glitch,
                          input string t1, input string t2);
    exp_t e1, e2;
    while (!bit_strobe) @(negedge clk);
    data_in = x;
    mode    = m;
    if (m) begin
      e1.lvl = ~x;
      e2.lvl = x;
    end else begin
      e1.lvl = ~model_prev;
      e2.lvl = x ? e1.lvl : ~e1.lvl;
    end
    e1.man = m; e2.man = m;
    e1.tag = t1; e2.tag = t2;
    model_prev = e2.lvl;
    @(posedge clk); #1;
    sb.push_back(e1);
    sb.push_back(e2);
    @(negedge clk);
    if (glitch) begin
      data_in = ~x;
      mode    = ~m;
    end
  endtask

  task automatic do_clear();
    while (sb.size() != 0) @(negedge clk);
    clr = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", line_out, 1'b0);
    check("R1", bit_strobe, 1'b1);
    clr = 1'b0;
    model_prev = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", line_out, 1'b0);
    check("R1", bit_strobe, 1'b1);
    clr = 1'b0;

    // FM0 pattern; first bit after clear starts at level 1
    send_bit(1'b1, 1'b0, 1'b0, "R1", "R4");
    send_bit(1'b1, 1'b0, 1'b0, "R3", "R4");
    send_bit(1'b0, 1'b0, 1'b0, "R3", "R4");
    send_bit(1'b0, 1'b0, 1'b0, "R3", "R4");
    send_bit(1'b1, 1'b0, 1'b0, "R3", "R4");
    send_bit(1'b0, 1'b0, 1'b0, "R3", "R4");
    send_bit(1'b1, 1'b0, 1'b0, "R7", "R7");

    // Manchester pattern
    send_bit(1'b0, 1'b1, 1'b0, "R5", "R5");
    send_bit(1'b1, 1'b1, 1'b0, "R5", "R5");
    send_bit(1'b1, 1'b1, 1'b0, "R5", "R5");
    send_bit(1'b0, 1'b1, 1'b0, "R5", "R5");

    // Switch back to FM0
    send_bit(1'b1, 1'b0, 1'b0, "R9", "R4");
    send_bit(1'b0, 1'b0, 1'b0, "R3", "R4");

    // Mid-bit changes on data and mode must be ignored
    send_bit(1'b0, 1'b0, 1'b1, "R3", "R6");
    send_bit(1'b1, 1'b0, 1'b1, "R3", "R2");
    send_bit(1'b0, 1'b1, 1'b1, "R5", "R6");
    send_bit(1'b1, 1'b1, 1'b1, "R5", "R2");
    send_bit(1'b1, 1'b0, 1'b1, "R9", "R6");

    // Clear in mid-stream, then FM0 restarts from level 1
    do_clear();
    send_bit(1'b0, 1'b0, 1'b0, "R1", "R4");
    send_bit(1'b1, 1'b0, 1'b0, "R3", "R4");

    // Long Manchester run for DC balance
    for (int i = 0; i < 200; i++)
      send_bit(1'($urandom_range(0, 1)), 1'b1, 1'b0, "R5", "R5");
    while (sb.size() != 0) @(negedge clk);
    check("R8", 1'(man_hi == man_lo), 1'b1);
    if (man_hi != man_lo)
      $display("FAIL R8: high slots %0d low slots %0d", man_hi, man_lo);

    // Mixed random run with random mid-bit disturbance
    for (int i = 0; i < 300; i++)
      send_bit(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), "R7", "R6");
    while (sb.size() != 0) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule